// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address of every beat of a memory read or write burst. A start pulse carries the first column of the burst together with a length code and an ordering select. From the next clock on, the block puts out one column per cycle with a valid strobe, and it raises a last-beat flag on the final beat of a bounded burst. The length code selects a burst of 1, 2, 4 or 8 beats, or a full-page mode that walks the whole 256-column row without end until it is stopped. The ordering select chooses between wrapping sequential order and interleaved order. Interleaved order is undefined for a full page.

A burst stops after the cycle in which the stop input is sampled high. A new start pulse can interrupt a running burst in any cycle, and the new burst follows with no idle cycle. The length code and ordering are captured only on the start pulse. A start with an illegal mode combination is refused: it ends any running burst and gives a one-cycle error pulse in its place.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `beat_vld_o`, `last_beat_o` and `mode_err_o` are low.
- R2: A legal start sampled at a clock edge puts beat 0 on `col_o`, with `beat_vld_o` high, after that same edge. Beat 0 equals the start column. One beat follows per cycle. Length codes 0, 1, 2 and 3 give exactly 1, 2, 4 and 8 beats, and `beat_vld_o` falls after the final beat.
- R3: In sequential order (`ilv_i`=0), beat n takes the low log2(L) bits from (start + n) mod L and keeps the upper bits of the start column.
- R4: In interleaved order (`ilv_i`=1), beat n equals the start column XOR n.
- R5: `last_beat_o` is high on beat L-1 of a bounded burst and low on every other beat.
- R6: Length code 7 with sequential order is full page. Beat n is (start + n) mod 256, the burst continues past 256 beats until it is stopped, and `last_beat_o` stays low.
- R7: When `stop_i` is high at an edge without a start, `beat_vld_o` is low after that edge. When start and stop are high together, the start wins.
- R8: A legal start during a running burst gives beat 0 of the new burst in the next cycle, with no invalid cycle in between.
- R9: A start with length codes 4 to 6, or with code 7 and interleaved order, gives no beats. It ends any running burst and raises `mode_err_o` for exactly one cycle.
- R10: `len_code_i`, `ilv_i` and `start_col_i` have no effect on a running burst. They are sampled only on a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a new burst |
| start_col_i | input | 8 | First column of the burst |
| len_code_i | input | 3 | Length code: 0..3 give 2^code beats, 7 gives full page, 4..6 are illegal |
| ilv_i | input | 1 | Ordering select: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | 8 | Column of the current beat |
| beat_vld_o | output | 1 | Current beat is valid |
| last_beat_o | output | 1 | Current beat is the final beat of a bounded burst |
| mode_err_o | output | 1 | One-cycle pulse after a refused start |

## Verification
A corrupted beat index or a corrupted captured base column shows up on `col_o` in the very next beat. A wrong captured length shows up when `last_beat_o` and the fall of `beat_vld_o` come one or more cycles early or late. A wrong ordering flag shows up from beat 1 on, because beat 0 is the same in both orders. Because of this, every beat of every burst is compared with an independent model of the column order.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;
  typedef enum logic [2:0] {
    LEN_1    = 3'd0,
    LEN_2    = 3'd1,
    LEN_4    = 3'd2,
    LEN_8    = 3'd3,
    LEN_PAGE = 3'd7
  } len_code_e;

  localparam int unsigned CODE_W      = 3;
  localparam int unsigned MAX_BND_LOG = 3;

  typedef struct packed {
    logic fp;
    logic ilv;
  } run_mode_t;
endpackage

// File: rtl/sbs_mode_decode.sv
module sbs_mode_decode
  import burst_col_seq_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              ilv_i,
  output logic              legal_o,
  output logic              fp_o,
  output logic [COL_W-1:0]  wrap_mask_o
);
  function automatic logic [COL_W-1:0] mask_of(input logic [CODE_W-1:0] c);
    logic [COL_W-1:0] one;
    one = {{(COL_W-1){1'b0}}, 1'b1};
    return (one << c) - one;
  endfunction

  always_comb begin
    fp_o        = (code_i == LEN_PAGE);
    legal_o     = (code_i <= CODE_W'(MAX_BND_LOG)) || (fp_o && !ilv_i);
    wrap_mask_o = fp_o ? {COL_W{1'b1}} : mask_of(code_i);
  end
endmodule

// File: rtl/sbs_beat_counter.sv
module sbs_beat_counter #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             kill_i,
  input  logic             final_i,
  output logic             active_o,
  output logic [COL_W-1:0] idx_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      idx_o    <= '0;
    end else if (load_i) begin
      active_o <= 1'b1;
      idx_o    <= '0;
    end else if (kill_i) begin
      active_o <= 1'b0;
    end else if (active_o) begin
      if (final_i) active_o <= 1'b0;
      else         idx_o    <= idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/sbs_col_gen.sv
module sbs_col_gen #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  function automatic logic [COL_W-1:0] seq_col(input logic [COL_W-1:0] b,
                                              input logic [COL_W-1:0] n,
                                              input logic [COL_W-1:0] m);
    return (b & ~m) | ((b + n) & m);
  endfunction

  function automatic logic [COL_W-1:0] ilv_col(input logic [COL_W-1:0] b,
                                              input logic [COL_W-1:0] n,
                                              input logic [COL_W-1:0] m);
    return b ^ (n & m);
  endfunction

  always_comb col_o = ilv_i ? ilv_col(base_i, idx_i, mask_i)
                            : seq_col(base_i, idx_i, mask_i);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_seq_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              ilv_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              beat_vld_o,
  output logic              last_beat_o,
  output logic              mode_err_o
);
  logic             start_ok_w;
  logic             start_fp_w;
  logic [COL_W-1:0] start_mask_w;
  logic             load_w;
  logic             kill_w;
  logic             final_w;
  logic             active_w;
  logic [COL_W-1:0] idx_w;
  logic             fp_run_w;

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  run_mode_t        mode_q;
  logic             err_q;

  sbs_mode_decode #(.COL_W(COL_W)) u_dec (
    .code_i      (len_code_i),
    .ilv_i       (ilv_i),
    .legal_o     (start_ok_w),
    .fp_o        (start_fp_w),
    .wrap_mask_o (start_mask_w)
  );

  assign load_w   = start_i && start_ok_w;
  assign kill_w   = (start_i && !start_ok_w) || stop_i;
  assign fp_run_w = active_w && mode_q.fp;
  assign final_w  = active_w && !mode_q.fp && ((idx_w & mask_q) == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      mode_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= start_i && !start_ok_w;
      if (load_w) begin
        base_q      <= start_col_i;
        mask_q      <= start_mask_w;
        mode_q.fp   <= start_fp_w;
        mode_q.ilv  <= ilv_i;
      end
    end
  end

  sbs_beat_counter #(.COL_W(COL_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_w),
    .kill_i   (kill_w),
    .final_i  (final_w),
    .active_o (active_w),
    .idx_o    (idx_w)
  );

  sbs_col_gen #(.COL_W(COL_W)) u_col (
    .base_i (base_q),
    .idx_i  (idx_w),
    .mask_i (mask_q),
    .ilv_i  (mode_q.ilv),
    .col_o  (col_o)
  );

  assign beat_vld_o  = active_w;
  assign last_beat_o = final_w;
  assign mode_err_o  = err_q;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int unsigned COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             beat_vld_o,
  input logic             last_beat_o,
  input logic             mode_err_o,
  input logic             start_ok_w,
  input logic             fp_run_w
);
  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && start_ok_w |=> beat_vld_o && (col_o == $past(start_col_i)));

  a_r5_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat_o |-> beat_vld_o);

  a_r5_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat_o && !start_i |=> !beat_vld_o);

  a_r6_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    fp_run_w |-> !last_beat_o);

  a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !start_i |=> !beat_vld_o);

  a_r9_refused: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !start_ok_w |=> mode_err_o && !beat_vld_o);

  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_i && !start_ok_w) |=> !mode_err_o);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .beat_vld_o  (beat_vld_o),
  .last_beat_o (last_beat_o),
  .mode_err_o  (mode_err_o),
  .start_ok_w  (start_ok_w),
  .fp_run_w    (fp_run_w)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [7:0] col_o;
  logic       beat_vld_o, last_beat_o, mode_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_col_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .stop_i(stop_i), .col_o(col_o),
    .beat_vld_o(beat_vld_o), .last_beat_o(last_beat_o), .mode_err_o(mode_err_o)
  );

  typedef struct packed {
    logic [7:0] col;
    logic [2:0] code;
    logic       ilv;
    logic [3:0] beats;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 3'd0, 1'b0, 4'd1},
    '{8'h37, 3'd0, 1'b1, 4'd1},
    '{8'h21, 3'd1, 1'b0, 4'd2},
    '{8'h21, 3'd1, 1'b1, 4'd2},
    '{8'h4E, 3'd2, 1'b0, 4'd4},
    '{8'h4E, 3'd2, 1'b1, 4'd4},
    '{8'hA5, 3'd3, 1'b0, 4'd8},
    '{8'hA5, 3'd3, 1'b1, 4'd8},
    '{8'hFF, 3'd3, 1'b0, 4'd8},
    '{8'h7A, 3'd3, 1'b1, 4'd8}
  };

  function automatic logic [7:0] model_col(input logic [7:0] s, input int code,
                                           input logic ilv, input int n);
    int len, lo;
    if (ilv) return s ^ 8'(n);
    if (code == 7) return 8'((int'(s) + n) % 256);
    len = 1 << code;
    lo  = int'(s) % len;
    return 8'(int'(s) - lo + (lo + n) % len);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic beat_chk(input string req, input logic [7:0] s, input int code,
                          input logic ilv, input int n, input bit is_last);
    logic [7:0] e;
    e = model_col(s, code, ilv, n);
    chk(beat_vld_o === 1'b1, {req, " vld"}, int'(beat_vld_o), 1);
    chk(col_o === e, {req, " col"}, int'(col_o), int'(e));
    chk(last_beat_o === is_last, "R5 last", int'(last_beat_o), int'(is_last));
  endtask

  task automatic pulse_start(input logic [7:0] c, input logic [2:0] code, input logic ilv);
    start_i = 1'b1; start_col_i = c; len_code_i = code; ilv_i = ilv;
    @(negedge clk);
    start_i = 1'b0;
    // R10: disturb mode inputs while the burst runs
    start_col_i = ~c; len_code_i = 3'd5; ilv_i = ~ilv;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(beat_vld_o === 1'b0 && last_beat_o === 1'b0 && mode_err_o === 1'b0,
        "R1 reset outputs", int'({beat_vld_o, last_beat_o, mode_err_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(beat_vld_o === 1'b0, "R1 idle", int'(beat_vld_o), 0);

    // table walk: R2 R3 R4 R5 R10
    for (int v = 0; v < NV; v++) begin
      pulse_start(VECS[v].col, VECS[v].code, VECS[v].ilv);
      for (int n = 0; n < int'(VECS[v].beats); n++) begin
        beat_chk(VECS[v].ilv ? "R4 R10" : "R3 R10", VECS[v].col, int'(VECS[v].code),
                 VECS[v].ilv, n, n == int'(VECS[v].beats) - 1);
        @(negedge clk);
      end
      chk(beat_vld_o === 1'b0, "R2 burst length", int'(beat_vld_o), 0);
      @(negedge clk);
    end

    // R6 full page across the 256 wrap and beyond
    pulse_start(8'hFC, 3'd7, 1'b0);
    for (int n = 0; n < 300; n++) begin
      beat_chk("R6 page", 8'hFC, 7, 1'b0, n, 1'b0);
      @(negedge clk);
    end
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk(beat_vld_o === 1'b0, "R7 stop page", int'(beat_vld_o), 0);

    // R7 stop mid burst
    pulse_start(8'h40, 3'd3, 1'b0);
    beat_chk("R7 pre", 8'h40, 3, 1'b0, 0, 1'b0);
    @(negedge clk);
    beat_chk("R7 pre", 8'h40, 3, 1'b0, 1, 1'b0);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk(beat_vld_o === 1'b0, "R7 stop", int'(beat_vld_o), 0);
    @(negedge clk);
    chk(beat_vld_o === 1'b0, "R7 stays idle", int'(beat_vld_o), 0);

    // R7 start and stop together: start wins
    stop_i = 1'b1;
    pulse_start(8'h13, 3'd1, 1'b0);
    stop_i = 1'b0;
    beat_chk("R7 start wins", 8'h13, 1, 1'b0, 0, 1'b0);
    @(negedge clk);
    beat_chk("R7 start wins", 8'h13, 1, 1'b0, 1, 1'b1);
    @(negedge clk);

    // R8 restart mid burst with no gap
    pulse_start(8'h80, 3'd3, 1'b0);
    beat_chk("R8 first", 8'h80, 3, 1'b0, 0, 1'b0);
    @(negedge clk);
    beat_chk("R8 first", 8'h80, 3, 1'b0, 1, 1'b0);
    pulse_start(8'h1B, 3'd2, 1'b1);
    for (int n = 0; n < 4; n++) begin
      beat_chk("R8 second", 8'h1B, 2, 1'b1, n, n == 3);
      @(negedge clk);
    end
    chk(beat_vld_o === 1'b0, "R8 end", int'(beat_vld_o), 0);

    // R9 refused page with interleave, during a running burst
    pulse_start(8'h55, 3'd3, 1'b0);
    beat_chk("R9 pre", 8'h55, 3, 1'b0, 0, 1'b0);
    pulse_start(8'h10, 3'd7, 1'b1);
    chk(mode_err_o === 1'b1, "R9 err page ilv", int'(mode_err_o), 1);
    chk(beat_vld_o === 1'b0, "R9 burst ended", int'(beat_vld_o), 0);
    @(negedge clk);
    chk(mode_err_o === 1'b0, "R9 err one cycle", int'(mode_err_o), 0);
    chk(beat_vld_o === 1'b0, "R9 no beats", int'(beat_vld_o), 0);

    // R9 reserved length code
    pulse_start(8'h22, 3'd5, 1'b0);
    chk(mode_err_o === 1'b1 && beat_vld_o === 1'b0, "R9 reserved code",
        int'({mode_err_o, beat_vld_o}), 2);
    @(negedge clk);
    chk(mode_err_o === 1'b0, "R9 err clears", int'(mode_err_o), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule